// File: doc/BRIEF.md
# TPM FIFO-Style Register Bank

This block answers the register accesses that a SPI frame decoder pulls out of the bus. Each access opens with a one-cycle request that carries a 24-bit register offset, a transfer length of 1 to 2**LEN_W bytes and a direction. After the request, write bytes arrive one per `wr_valid` strobe. Read bytes are presented on `rd_data` and advance on each `rd_pop`. Multi-byte values go out least significant byte first.

The bank holds the state of a single locality. The access byte has one-hot write semantics, so one write either claims or releases the locality. The bank also holds an interrupt-enable word as plain storage. The status, capability, identity and revision words are read-only constants. A write to any offset that has no writable storage is dropped and sets a sticky debug flag, which stays set until reset.

Top module: `tpm_regbank`

## Requirements
- R1: After reset, the access byte (offset 0x000) reads 0x80, the status word (offset 0x018) reads 0x04004000 (family field bits 27:26 = 1, burst field bits 23:8 = 64), and `dbg_bad_wr` is 0.
- R2: The capability word (offset 0x014) reads 0x30000615. The identity word (offset 0xF00) reads {DEV_ID, VEN_ID}, with the device ID in bits 31:16. The revision word (offset 0xF04) reads 0.
- R3: Read bytes come out least significant first. Read byte positions 4 and higher return 0xFF. Every byte of an offset with no readable register (for example 0x028) returns 0xFF. Bytes 1 to 3 of the access byte read 0x00. With no read in progress, `rd_data` is 0xFF.
- R4: Writing the access byte with the value 0x02 sets bit 5 (locality active).
- R5: Writing the access byte with the value 0x20 clears bit 5.
- R6: An access-byte write of 0x00, of a value with more than one bit set, or of any single bit other than bit 1 or bit 5 leaves the register unchanged and does not set the debug flag.
- R7: Only the first byte of a write to the access byte is used. Later bytes of the same write are ignored.
- R8: The interrupt-enable word (offset 0x008) stores write bytes 0 to 3 into byte lanes 0 to 3 and reads them back. Write bytes at positions 4 and higher are dropped.
- R9: A write byte to any offset other than the access byte or the interrupt-enable word is discarded and sets `dbg_bad_wr`. The flag stays at 1 until reset.
- R10: `req_len` holds the length minus one. Write bytes beyond that length are ignored. Once that many read bytes have been popped, `rd_data` returns 0xFF.
- R11: A write byte presented in the same cycle as its request counts as byte 0 of that request. A `rd_pop` in the same cycle as a request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Starts a new access |
| req_addr | input | 24 | Register offset |
| req_len | input | LEN_W | Length in bytes minus one |
| req_rd | input | 1 | 1 = read, 0 = write |
| wr_valid | input | 1 | Write byte strobe |
| wr_data | input | 8 | Write byte |
| rd_pop | input | 1 | Advances to the next read byte |
| rd_data | output | 8 | Current read byte |
| dbg_bad_wr | output | 1 | Sticky flag: a write hit a non-writable offset |

## Verification
Two events can fall in the same cycle: a request opening a new access, and a data byte or pop for the stream. The bench provokes this by driving `wr_valid` together with `req_valid` to the access byte, and `rd_pop` together with a read request to the status word. It judges the result by reading the access byte back and by checking that the first read byte is still byte 0. A behavioural model, updated from the same inputs, predicts `rd_data` and `dbg_bad_wr` and is compared on every clock.

// File: rtl/tpm_regbank_pkg.sv
package tpm_regbank_pkg;

   localparam int unsigned OFS_W = 24;

   localparam logic [OFS_W-1:0] OFS_ACCESS  = 24'h000;
   localparam logic [OFS_W-1:0] OFS_INT_EN  = 24'h008;
   localparam logic [OFS_W-1:0] OFS_INT_VEC = 24'h00C;
   localparam logic [OFS_W-1:0] OFS_INT_STS = 24'h010;
   localparam logic [OFS_W-1:0] OFS_CAPAB   = 24'h014;
   localparam logic [OFS_W-1:0] OFS_STATUS  = 24'h018;
   localparam logic [OFS_W-1:0] OFS_DFIFO   = 24'h028;
   localparam logic [OFS_W-1:0] OFS_IFID    = 24'h030;
   localparam logic [OFS_W-1:0] OFS_IDENT   = 24'hF00;
   localparam logic [OFS_W-1:0] OFS_REV     = 24'hF04;

   localparam int unsigned ACC_VALID_BIT = 7;
   localparam int unsigned ACC_LOC_BIT   = 5;
   localparam int unsigned ACC_REQ_BIT   = 1;

   localparam logic [31:0] CAPAB_WORD = (32'd3 << 28) | (32'd3 << 9) | 32'h15;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ACCESS,
      SEL_INT_EN,
      SEL_CAPAB,
      SEL_STATUS,
      SEL_IDENT,
      SEL_REV
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
      reg_sel_e s;
      case (a)
         OFS_ACCESS: s = SEL_ACCESS;
         OFS_INT_EN: s = SEL_INT_EN;
         OFS_CAPAB:  s = SEL_CAPAB;
         OFS_STATUS: s = SEL_STATUS;
         OFS_IDENT:  s = SEL_IDENT;
         OFS_REV:    s = SEL_REV;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/tpm_xfer_track.sv
module tpm_xfer_track #(
   parameter int unsigned LEN_W = 6,
   parameter int unsigned OFS_W = 24,
   localparam int unsigned IDX_W = LEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OFS_W-1:0] req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_rd,
   input  logic             wr_valid,
   input  logic             rd_pop,
   output logic             wr_take,
   output logic [OFS_W-1:0] wr_addr,
   output logic [IDX_W-1:0] wr_idx,
   output logic             rd_live,
   output logic [OFS_W-1:0] rd_addr,
   output logic [IDX_W-1:0] rd_idx
);

   logic [OFS_W-1:0] addr_q;
   logic [LEN_W-1:0] len_q;
   logic [IDX_W-1:0] idx_q;
   logic             rd_q;
   logic             act_q;

   logic [LEN_W-1:0] eff_len;
   logic             eff_rd;
   logic             eff_act;
   logic             pop_take;

   always_comb begin
      wr_addr  = req_valid ? req_addr : addr_q;
      eff_len  = req_valid ? req_len  : len_q;
      eff_rd   = req_valid ? req_rd   : rd_q;
      wr_idx   = req_valid ? '0       : idx_q;
      eff_act  = req_valid | act_q;
      wr_take  = wr_valid & eff_act & ~eff_rd & (wr_idx <= {1'b0, eff_len});
      rd_live  = act_q & rd_q & (idx_q <= {1'b0, len_q});
      pop_take = rd_pop & ~req_valid & rd_live;
      rd_addr  = addr_q;
      rd_idx   = idx_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         len_q  <= '0;
         idx_q  <= '0;
         rd_q   <= 1'b0;
         act_q  <= 1'b0;
      end else if (req_valid) begin
         addr_q <= req_addr;
         len_q  <= req_len;
         rd_q   <= req_rd;
         act_q  <= 1'b1;
         idx_q  <= wr_take ? IDX_W'(1) : '0;
      end else if (wr_take || pop_take) begin
         idx_q  <= idx_q + IDX_W'(1);
      end
   end

   p_idx_bound_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (idx_q <= ({1'b0, len_q} + IDX_W'(1))));

   p_pop_same_cycle_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_rd) |=> (idx_q == '0));

endmodule

// File: rtl/tpm_access_reg.sv
module tpm_access_reg
   import tpm_regbank_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_byte,
   output logic [7:0] acc_byte
);

   logic loc_q;
   logic one_hot;

   assign one_hot = $onehot(wr_byte);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         loc_q <= 1'b0;
      end else if (wr_en && one_hot) begin
         if (wr_byte[ACC_REQ_BIT])
            loc_q <= 1'b1;
         else if (wr_byte[ACC_LOC_BIT])
            loc_q <= 1'b0;
      end
   end

   always_comb begin
      acc_byte = '0;
      acc_byte[ACC_VALID_BIT] = 1'b1;
      acc_byte[ACC_LOC_BIT]   = loc_q;
   end

   p_acc_grant_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_byte == 8'h02) |=> loc_q);

   p_acc_release_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_byte == 8'h20) |=> !loc_q);

   p_acc_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_byte == 8'h02 || wr_byte == 8'h20)) |=> $stable(loc_q));

endmodule

// File: rtl/tpm_read_mux.sv
module tpm_read_mux
   import tpm_regbank_pkg::*;
#(
   parameter int unsigned IDX_W = 7
) (
   input  reg_sel_e         sel,
   input  logic             live,
   input  logic [IDX_W-1:0] idx,
   input  logic             inten_ok,
   input  logic [7:0]       acc_byte,
   input  logic [31:0]      inten_word,
   input  logic [31:0]      status_word,
   input  logic [31:0]      ident_word,
   input  logic [31:0]      rev_word,
   output logic [7:0]       rd_byte
);

   logic [31:0] word;
   logic        known;

   always_comb begin
      known = 1'b1;
      word  = '0;
      case (sel)
         SEL_ACCESS: word = {24'h0, acc_byte};
         SEL_INT_EN: begin word = inten_word; known = inten_ok; end
         SEL_CAPAB:  word = CAPAB_WORD;
         SEL_STATUS: word = status_word;
         SEL_IDENT:  word = ident_word;
         SEL_REV:    word = rev_word;
         default:    known = 1'b0;
      endcase
      if (!live || !known || idx > IDX_W'(3))
         rd_byte = 8'hFF;
      else
         rd_byte = word[idx[1:0]*8 +: 8];
   end

endmodule

// File: rtl/tpm_regbank.sv
module tpm_regbank
   import tpm_regbank_pkg::*;
#(
   parameter int unsigned LEN_W       = 6,
   parameter logic [15:0] DEV_ID      = 16'h0042,
   parameter logic [15:0] VEN_ID      = 16'h1234,
   parameter int unsigned FAMILY      = 1,
   parameter int unsigned BURST       = 64,
   parameter bit          IMPL_INT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [23:0]      req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_rd,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   input  logic             rd_pop,
   output logic [7:0]       rd_data,
   output logic             dbg_bad_wr
);

   localparam int unsigned IDX_W = LEN_W + 1;
   localparam logic [31:0] STATUS_WORD = (32'(FAMILY) << 26) | (32'(BURST) << 8);
   localparam logic [31:0] IDENT_WORD  = {DEV_ID, VEN_ID};

   if (LEN_W < 2 || LEN_W > 8) begin : g_bad_len
      $error("tpm_regbank: LEN_W must lie in 2..8");
   end
   if (FAMILY > 3) begin : g_bad_family
      $error("tpm_regbank: FAMILY must fit in two bits");
   end
   if (BURST > 65535) begin : g_bad_burst
      $error("tpm_regbank: BURST must fit in sixteen bits");
   end

   logic             wr_take;
   logic [23:0]      wr_addr;
   logic [IDX_W-1:0] wr_idx;
   logic             rd_live;
   logic [23:0]      rd_addr;
   logic [IDX_W-1:0] rd_idx;
   reg_sel_e         wr_sel;
   reg_sel_e         rd_sel;
   logic [7:0]       acc_byte;
   logic [31:0]      inten_word;
   logic             inten_ok;
   logic             inten_wr;
   logic             acc_wr;
   logic             bad_hit;
   logic             bad_q;

   tpm_xfer_track #(.LEN_W(LEN_W), .OFS_W(OFS_W)) u_track (
      .clk, .rst_n, .req_valid, .req_addr, .req_len, .req_rd,
      .wr_valid, .rd_pop,
      .wr_take, .wr_addr, .wr_idx, .rd_live, .rd_addr, .rd_idx
   );

   assign wr_sel   = decode_ofs(wr_addr);
   assign rd_sel   = decode_ofs(rd_addr);
   assign acc_wr   = wr_take && wr_sel == SEL_ACCESS && wr_idx == '0;
   assign inten_wr = wr_take && wr_sel == SEL_INT_EN && wr_idx < IDX_W'(4);
   assign bad_hit  = wr_take && wr_sel != SEL_ACCESS &&
                     !(wr_sel == SEL_INT_EN && inten_ok);

   tpm_access_reg u_access (
      .clk, .rst_n, .wr_en(acc_wr), .wr_byte(wr_data), .acc_byte
   );

   if (IMPL_INT_EN) begin : g_inten
      logic [31:0] inten_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            inten_q <= '0;
         else if (inten_wr)
            inten_q[wr_idx[1:0]*8 +: 8] <= wr_data;
      end
      assign inten_word = inten_q;
      assign inten_ok   = 1'b1;
   end else begin : g_no_inten
      assign inten_word = '0;
      assign inten_ok   = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bad_q <= 1'b0;
      else if (bad_hit)
         bad_q <= 1'b1;
   end
   assign dbg_bad_wr = bad_q;

   tpm_read_mux #(.IDX_W(IDX_W)) u_rmux (
      .sel(rd_sel), .live(rd_live), .idx(rd_idx), .inten_ok,
      .acc_byte, .inten_word, .status_word(STATUS_WORD),
      .ident_word(IDENT_WORD), .rev_word(32'h0), .rd_byte(rd_data)
   );

   p_flag_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      bad_q |=> bad_q);

   p_flag_rise_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_q) |-> $past(wr_valid));

   p_idle_ff_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_live |-> rd_data == 8'hFF);

endmodule

// File: tb/tpm_regbank_tb_top.sv
module tpm_regbank_tb_top;

   localparam int LEN_W = 6;
   localparam logic [31:0] EXP_STS   = 32'h0400_4000;
   localparam logic [31:0] EXP_CAP   = 32'h3000_0615;
   localparam logic [31:0] EXP_IDENT = 32'h0042_1234;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [23:0]      req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_rd = 1'b0;
   logic             wr_valid = 1'b0;
   logic [7:0]       wr_data = '0;
   logic             rd_pop = 1'b0;
   logic [7:0]       rd_data;
   logic             dbg_bad_wr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tpm_regbank #(.LEN_W(LEN_W), .DEV_ID(16'h0042), .VEN_ID(16'h1234)) dut_i (
      .clk, .rst_n, .req_valid, .req_addr, .req_len, .req_rd,
      .wr_valid, .wr_data, .rd_pop, .rd_data, .dbg_bad_wr
   );

   // ---------------- behavioural reference model ----------------
   bit          m_loc, m_bad, m_rd, m_act;
   logic [31:0] m_inten;
   int          m_addr, m_len, m_idx;

   always @(posedge clk) begin : model
      int  ea, el, ei;
      bit  er, eact, wtake, ptake, live;
      if (!rst_n) begin
         m_loc = 0; m_bad = 0; m_rd = 0; m_act = 0;
         m_inten = 0; m_addr = 0; m_len = 0; m_idx = 0;
      end else begin
         ea   = req_valid ? int'(req_addr) : m_addr;
         el   = req_valid ? int'(req_len)  : m_len;
         er   = req_valid ? req_rd         : m_rd;
         ei   = req_valid ? 0              : m_idx;
         eact = req_valid | m_act;
         wtake = wr_valid && eact && !er && ei <= el;
         live  = m_act && m_rd && m_idx <= m_len;
         ptake = rd_pop && !req_valid && live;
         if (wtake) begin
            if (ea == 0) begin
               if (ei == 0 && wr_data == 8'h02) m_loc = 1;
               else if (ei == 0 && wr_data == 8'h20) m_loc = 0;
            end else if (ea == 8) begin
               if (ei < 4) m_inten[ei*8 +: 8] = wr_data;
            end else m_bad = 1;
         end
         if (req_valid) begin
            m_addr = ea; m_len = el; m_rd = er; m_act = 1;
            m_idx = wtake ? 1 : 0;
         end else if (wtake || ptake) m_idx = m_idx + 1;
      end
   end

   function automatic logic [7:0] model_byte();
      logic [31:0] w;
      if (!(m_act && m_rd && m_idx <= m_len) || m_idx >= 4) return 8'hFF;
      case (m_addr)
         'h000:   w = {24'h0, 1'b1, 1'b0, m_loc, 5'b0};
         'h008:   w = m_inten;
         'h014:   w = EXP_CAP;
         'h018:   w = EXP_STS;
         'hF00:   w = EXP_IDENT;
         'hF04:   w = 32'h0;
         default: return 8'hFF;
      endcase
      return w[m_idx*8 +: 8];
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (rd_data !== model_byte()) begin
            errors++;
            $display("FAIL R3 model rd_data: actual %02h expected %02h at %0t",
                     rd_data, model_byte(), $time);
         end
         checks++;
         if (dbg_bad_wr !== m_bad) begin
            errors++;
            $display("FAIL R9 model flag: actual %0b expected %0b at %0t",
                     dbg_bad_wr, m_bad, $time);
         end
      end
   end

   // ---------------- directed helpers ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [23:0] a, input int lenm1,
                           input logic [63:0] bytes, input int n, input bit same);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_len = LEN_W'(lenm1); req_rd = 0;
      wr_valid = same; wr_data = bytes[7:0];
      for (int i = (same ? 1 : 0); i < n; i++) begin
         @(negedge clk);
         req_valid = 0; wr_valid = 1; wr_data = bytes[i*8 +: 8];
      end
      @(negedge clk);
      req_valid = 0; wr_valid = 0;
   endtask

   task automatic do_read(input string tag, input logic [23:0] a, input int lenm1,
                          input logic [63:0] exp, input int n, input bit pop_at_req);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_len = LEN_W'(lenm1); req_rd = 1;
      rd_pop = pop_at_req;
      @(negedge clk);
      req_valid = 0; rd_pop = 0;
      for (int i = 0; i < n; i++) begin
         chk($sformatf("%s byte %0d", tag, i), {24'h0, rd_data}, {24'h0, exp[i*8 +: 8]});
         rd_pop = 1;
         @(negedge clk);
         rd_pop = 0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 flag after reset", {31'h0, dbg_bad_wr}, 0);
      chk("R3 idle read byte", {24'h0, rd_data}, 32'hFF);
      do_read("R1 access reset", 24'h000, 0, 64'h80, 1, 0);
      do_read("R1 status reset", 24'h018, 3, {32'h0, EXP_STS}, 4, 0);
      do_read("R2 capability", 24'h014, 3, {32'h0, EXP_CAP}, 4, 0);
      do_read("R2 identity", 24'hF00, 3, {32'h0, EXP_IDENT}, 4, 0);
      do_read("R2 revision", 24'hF04, 3, 64'h0, 4, 0);
      do_read("R3 beyond four", 24'h014, 5, {16'hFFFF, EXP_CAP}, 6, 0);
      do_read("R3 unknown offset", 24'h028, 1, 64'hFFFF, 2, 0);
      do_read("R3 access upper bytes", 24'h000, 3, 64'h80, 4, 0);

      do_write(24'h000, 0, 64'h02, 1, 0);
      do_read("R4 grant", 24'h000, 0, 64'hA0, 1, 0);
      do_write(24'h000, 0, 64'h20, 1, 0);
      do_read("R5 release", 24'h000, 0, 64'h80, 1, 0);
      do_write(24'h000, 0, 64'h02, 1, 0);
      do_write(24'h000, 0, 64'h00, 1, 0);
      do_write(24'h000, 0, 64'h22, 1, 0);
      do_write(24'h000, 0, 64'h01, 1, 0);
      do_write(24'h000, 0, 64'h80, 1, 0);
      do_read("R6 ignored values", 24'h000, 0, 64'hA0, 1, 0);
      chk("R6 no flag", {31'h0, dbg_bad_wr}, 0);

      do_write(24'h000, 1, 64'h2040, 2, 0);
      do_read("R7 later byte ignored", 24'h000, 0, 64'hA0, 1, 0);
      do_write(24'h000, 1, 64'h0220, 2, 0);
      do_read("R7 first byte only", 24'h000, 0, 64'h80, 1, 0);

      do_write(24'h008, 5, 64'hBBAA_4433_2211, 6, 0);
      do_read("R8 int enable", 24'h008, 5, 64'hFFFF_4433_2211, 6, 0);
      chk("R8 no flag", {31'h0, dbg_bad_wr}, 0);

      do_write(24'h008, 0, 64'h6655, 2, 0);
      do_read("R10 write length", 24'h008, 3, 64'h4433_2255, 4, 0);
      do_read("R10 read past length", 24'h014, 1, {48'hFF, 16'h0615}, 3, 0);

      do_write(24'h000, 0, 64'h02, 1, 1);
      do_read("R11 byte with request", 24'h000, 0, 64'hA0, 1, 0);
      do_read("R11 pop with request", 24'h018, 3, {32'h0, EXP_STS}, 4, 1);

      do_write(24'h018, 3, 64'h1122_3344, 4, 0);
      chk("R9 flag set", {31'h0, dbg_bad_wr}, 1);
      do_read("R9 status unchanged", 24'h018, 3, {32'h0, EXP_STS}, 4, 0);
      do_write(24'h000, 0, 64'h20, 1, 0);
      chk("R9 flag sticky", {31'h0, dbg_bad_wr}, 1);

      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 flag cleared by reset", {31'h0, dbg_bad_wr}, 0);
      do_read("R1 access after reset", 24'h000, 0, 64'h80, 1, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule